// File: doc/BRIEF.md
# Three-Wire Serial Register Writer

This block is a write-only slave on a three-wire serial link made of a clock line, a data line and an active-high enable line. It runs on a fast system clock. All three serial lines pass through synchronizers, and the block detects rising edges of the serial clock in the system clock domain. While enable is high, the block shifts in one data bit on each serial clock rise, most significant bit first. It groups the bits into bytes.

The first byte of a window selects the device. Its upper two bits must be `01` and the next five bits must match the strap pins. The second byte loads a register pointer. Every complete byte after that is written to the register the pointer names, and the pointer then advances. All 22 eight-bit registers are presented side by side on one wide output bus, which the downstream light-driver logic reads directly.

A byte is written at the moment it completes. The first data byte completes on the 24th serial clock edge, so a window with fewer edges can never write anything. A trailing group of fewer than eight bits never completes, so it is dropped.

Top module: `twsr_writer`

## Requirements
- R1: When the active-low reset is applied, all 22 registers read 0x00 on `regs_o`.
- R2: On each serial clock rise while enable is high, the data line is sampled. Bytes are assembled most significant bit first, and a data byte lands unchanged in its target register.
- R3: The first byte is accepted only if bits [7:6] equal `01` and bits [5:1] equal `dev_strap[4:0]`. Bit 0 is ignored. If the first byte does not match, the rest of the window writes nothing.
- R4: The second byte sets the register pointer, and the third byte is written to the register that pointer names.
- R5: Each further complete byte in the same window is written to the next register index.
- R6: After register 0x15 has been written, the next byte goes to register 0x00.
- R7: A window that ends after 23 or fewer serial clock rises changes no register.
- R8: A trailing group of fewer than eight bits at the end of a window changes no register.
- R9: When enable goes low, the frame logic returns to idle. The next window is decoded from its first byte, whatever was cut short before.
- R10: If the pointer is above 0x15, data bytes are dropped while the pointer still advances. The pointer wraps from 0xFF to 0x00, and writing resumes at register 0x00.
- R11: A reset applied in the middle of an open window clears the registers and the frame logic. The next window decodes normally.
- R12: Serial clock rises while enable is low change no register and do not disturb the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock line |
| ser_dat | input | 1 | Serial data line |
| ser_en | input | 1 | Serial enable line, active high for one frame window |
| dev_strap | input | 5 | Strap pins that form bits [5:1] of the device address |
| regs_o | output | 176 | Register contents; register n sits at bits [8n+7:8n] |

## Verification
Each serial line change reaches the synchronized level two system clock edges after it is driven. A completed byte is written on the third edge. The result therefore shows on `regs_o` three system clock edges after the serial clock rise that completes the byte.

The bench drives all inputs on the falling system clock edge. It holds each serial clock level for at least four system clocks. It compares the whole register bank against its arithmetic model only after enable has been low for eight system clocks, when every write of the window has long been due.

// File: rtl/twsr_pkg.sv
package twsr_pkg;
   localparam int unsigned BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;
   typedef enum logic [1:0] {
      PH_DEV  = 2'd0,
      PH_REG  = 2'd1,
      PH_DATA = 2'd2,
      PH_SKIP = 2'd3
   } phase_e;
endpackage

// File: rtl/twsr_sync.sv
module twsr_sync #(
   parameter int unsigned LINES  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] din,
   output logic [LINES-1:0] level
);
   if (STAGES < 2) begin : g_bad_stages
      $error("twsr_sync: STAGES must be at least 2");
   end
   if (LINES < 1) begin : g_bad_lines
      $error("twsr_sync: LINES must be at least 1");
   end

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], din[i]};
      end
      assign level[i] = chain_q[STAGES-1];
   end
endmodule

// File: rtl/twsr_frame.sv
module twsr_frame
   import twsr_pkg::*;
#(
   parameter int unsigned NUM_REGS   = 22,
   parameter int unsigned STRAP_W    = 5,
   parameter int unsigned DEV_PREFIX = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               sclk,
   input  logic               dat,
   input  logic [STRAP_W-1:0] strap,
   output logic               wr_en,
   output byte_t              wr_addr,
   output byte_t              wr_data
);
   localparam int unsigned PREFIX_W = BYTE_W - 1 - STRAP_W;
   localparam int unsigned BIT_W    = $clog2(BYTE_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
   localparam byte_t REG_LIM  = byte_t'(NUM_REGS);
   localparam byte_t LAST_REG = byte_t'(NUM_REGS - 1);

   if (NUM_REGS < 1 || NUM_REGS > 255) begin : g_bad_regs
      $error("twsr_frame: NUM_REGS must be 1..255");
   end
   if (STRAP_W < 1 || STRAP_W > BYTE_W - 2) begin : g_bad_strap
      $error("twsr_frame: STRAP_W out of range");
   end

   phase_e                 phase_q;
   logic [BIT_W-1:0]       bit_q;
   logic [BYTE_W-2:0]      shf_q;
   byte_t                  ptr_q;
   logic                   sclk_d;
   logic                   rise;
   logic                   byte_done;
   logic                   dev_hit;
   byte_t                  nxt_byte;
   byte_t                  ptr_inc;

   assign rise      = sclk & ~sclk_d;
   assign nxt_byte  = {shf_q, dat};
   assign byte_done = en & rise & (bit_q == LAST_BIT);
   assign dev_hit   = (nxt_byte[BYTE_W-1:1] == {PREFIX_W'(DEV_PREFIX), strap});
   assign ptr_inc   = (ptr_q == LAST_REG) ? '0 : ptr_q + 8'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_DEV;
         bit_q   <= '0;
         shf_q   <= '0;
         ptr_q   <= '0;
         sclk_d  <= 1'b0;
      end else begin
         sclk_d <= sclk;
         if (!en) begin
            phase_q <= PH_DEV;
            bit_q   <= '0;
            shf_q   <= '0;
         end else if (rise) begin
            shf_q <= nxt_byte[BYTE_W-2:0];
            bit_q <= bit_q + 1'b1;
            if (bit_q == LAST_BIT) begin
               case (phase_q)
                  PH_DEV:  phase_q <= dev_hit ? PH_REG : PH_SKIP;
                  PH_REG:  begin
                     ptr_q   <= nxt_byte;
                     phase_q <= PH_DATA;
                  end
                  PH_DATA: ptr_q <= ptr_inc;
                  default: phase_q <= PH_SKIP;
               endcase
            end
         end
      end
   end

   assign wr_en   = byte_done & (phase_q == PH_DATA) & (ptr_q < REG_LIM);
   assign wr_addr = ptr_q;
   assign wr_data = nxt_byte;

   // R9
   idle_on_low_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (bit_q == '0) && (phase_q == PH_DEV));

   // R6
   ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && phase_q == PH_DATA && ptr_q == LAST_REG) |=> (ptr_q == '0));

   // R3
   dev_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && phase_q == PH_DEV && !dev_hit) |=> (phase_q == PH_SKIP));
endmodule

// File: rtl/twsr_regfile.sv
module twsr_regfile
   import twsr_pkg::*;
#(
   parameter int unsigned NUM_REGS = 22
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  byte_t                      wr_addr,
   input  byte_t                      wr_data,
   output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      byte_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                q <= '0;
         else if (wr_en && wr_addr == byte_t'(r))   q <= wr_data;
      end
      assign regs_o[r*BYTE_W +: BYTE_W] = q;
   end

   // R10
   addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_addr < byte_t'(NUM_REGS)));

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(regs_o));

   // R2
   land_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (regs_o[BYTE_W*$past(wr_addr) +: BYTE_W] == $past(wr_data)));
endmodule

// File: rtl/twsr_writer.sv
module twsr_writer
   import twsr_pkg::*;
#(
   parameter int unsigned NUM_REGS    = 22,
   parameter int unsigned STRAP_W     = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ser_clk,
   input  logic                       ser_dat,
   input  logic                       ser_en,
   input  logic [STRAP_W-1:0]         dev_strap,
   output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
   localparam int unsigned N_LINES = 3;

   logic [N_LINES-1:0] lvl;
   logic               wr_en;
   byte_t              wr_addr;
   byte_t              wr_data;

   twsr_sync #(.LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({ser_en, ser_dat, ser_clk}),
      .level (lvl)
   );

   twsr_frame #(.NUM_REGS(NUM_REGS), .STRAP_W(STRAP_W)) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (lvl[2]),
      .sclk    (lvl[0]),
      .dat     (lvl[1]),
      .strap   (dev_strap),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data)
   );

   twsr_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .regs_o  (regs_o)
   );
endmodule

// File: tb/test_twsr_writer.sv
module test_twsr_writer;
   localparam int CLK_NS = 10;
   localparam int NREG   = 22;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sc = 1'b0, sd = 1'b0, se = 1'b0;
   logic [4:0] strap = 5'd0;
   logic [NREG*8-1:0] regs;

   int  vectors = 0;
   int  miscompares = 0;
   bit  finished = 1'b0;
   logic [7:0] exp_q [NREG];
   logic [7:0] fb [16];

   always #(CLK_NS/2) clk = ~clk;

   twsr_writer #(.NUM_REGS(NREG)) i_twsr_writer (
      .clk(clk), .rst_n(rst_n), .ser_clk(sc), .ser_dat(sd), .ser_en(se),
      .dev_strap(strap), .regs_o(regs)
   );

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      sd = b; idle(3);
      sc = 1'b1; idle(4);
      sc = 1'b0; idle(2);
   endtask

   function automatic logic [7:0] dev_byte(input logic [4:0] s, input logic lsb);
      return {2'b01, s, lsb};
   endfunction

   // Model: only full bytes count; first must match, second is pointer.
   task automatic frame(input int nbytes, input int extra);
      logic [7:0] ptr;
      se = 1'b1; idle(4);
      for (int i = 0; i < nbytes; i++)
         for (int k = 7; k >= 0; k--) send_bit(fb[i][k]);
      for (int k = 0; k < extra; k++) send_bit(k[0] ^ 1'b1);
      idle(2); se = 1'b0; sd = 1'b0; idle(8);
      if (nbytes >= 3 && fb[0][7:1] == {2'b01, strap}) begin
         ptr = fb[1];
         for (int i = 2; i < nbytes; i++) begin
            if (ptr < 8'(NREG)) exp_q[ptr] = fb[i];
            ptr = (ptr == 8'(NREG - 1)) ? 8'd0 : ptr + 8'd1;
         end
      end
   endtask

   task automatic check_all(input string tag);
      for (int r = 0; r < NREG; r++) begin
         vectors++;
         if (regs[r*8 +: 8] !== exp_q[r]) begin
            miscompares++;
            $display("FAIL %s reg %0d actual %02h expected %02h", tag, r, regs[r*8 +: 8], exp_q[r]);
         end
      end
   endtask

   task automatic clear_model();
      for (int r = 0; r < NREG; r++) exp_q[r] = 8'h00;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      clear_model();
      idle(5); rst_n = 1'b1; idle(5);
      check_all("R1");

      // R4: every start register with a single data byte
      for (int s = 0; s < NREG; s++) begin
         fb[0] = dev_byte(strap, s[0]); fb[1] = 8'(s); fb[2] = 8'(s * 37 + 1);
         frame(3, 0);
         check_all("R4");
      end

      // R2: MSB-first bit patterns into one register
      begin
         logic [7:0] pats [6];
         pats = '{8'h80, 8'h01, 8'hFF, 8'h00, 8'hAA, 8'h55};
         for (int p = 0; p < 6; p++) begin
            fb[0] = dev_byte(strap, 1'b0); fb[1] = 8'd3; fb[2] = pats[p];
            frame(3, 0);
            check_all("R2");
         end
      end

      // R5: burst of six data bytes from register 2
      fb[0] = dev_byte(strap, 1'b1); fb[1] = 8'd2;
      for (int i = 0; i < 6; i++) fb[2+i] = 8'(8'hE0 + i);
      frame(8, 0);
      check_all("R5");

      // R6: burst across 0x15 -> 0x00
      fb[0] = dev_byte(strap, 1'b0); fb[1] = 8'h14;
      for (int i = 0; i < 5; i++) fb[2+i] = 8'(8'h71 + 3*i);
      frame(7, 0);
      check_all("R6");

      // R10: out-of-range start, pointer runs to 0xFF then wraps to 0x00
      fb[0] = dev_byte(strap, 1'b0); fb[1] = 8'hFE;
      fb[2] = 8'h11; fb[3] = 8'h22; fb[4] = 8'h33; fb[5] = 8'h44;
      frame(6, 0);
      check_all("R10");
      fb[1] = 8'h30; fb[2] = 8'h99; fb[3] = 8'h98;
      frame(4, 0);
      check_all("R10");

      // R3: sweep of all strap values, matching and non-matching first bytes
      for (int st = 0; st < 32; st++) begin
         strap = 5'(st);
         fb[0] = dev_byte(strap, st[1]); fb[1] = 8'(st % NREG); fb[2] = 8'(st) ^ 8'hC3;
         frame(3, 0);
         check_all("R3");
         if (st[0]) fb[0] = dev_byte(strap ^ 5'(1 << (st % 5)), 1'b0);
         else       fb[0] = {2'b10, strap, 1'b0};
         fb[1] = 8'(st % NREG); fb[2] = 8'h5E;
         frame(3, 0);
         check_all("R3");
      end
      strap = 5'd9;

      // R7: 23 edges and 16 edges write nothing
      fb[0] = dev_byte(strap, 1'b0); fb[1] = 8'd7; fb[2] = 8'hB7;
      frame(2, 7);
      check_all("R7");
      frame(2, 0);
      check_all("R7");

      // R8: trailing partial bytes are dropped
      fb[0] = dev_byte(strap, 1'b0); fb[1] = 8'd10; fb[2] = 8'h3C; fb[3] = 8'hC3;
      frame(3, 5);
      check_all("R8");
      frame(4, 7);
      check_all("R8");

      // R12: serial clocks with enable low
      for (int i = 0; i < 20; i++) begin
         sd = i[1]; idle(2); sc = 1'b1; idle(4); sc = 1'b0; idle(2);
      end
      check_all("R12");
      fb[0] = dev_byte(strap, 1'b1); fb[1] = 8'd12; fb[2] = 8'h6D;
      frame(3, 0);
      check_all("R12");

      // R9: aborted window, then a fresh frame decodes from its first byte
      se = 1'b1; idle(4);
      for (int k = 0; k < 5; k++) send_bit(k[0]);
      idle(2); se = 1'b0; idle(8);
      check_all("R9");
      fb[0] = dev_byte(strap, 1'b0); fb[1] = 8'd15; fb[2] = 8'h4B; fb[3] = 8'hB4;
      frame(4, 0);
      check_all("R9");

      // R11: reset in the middle of an open window
      se = 1'b1; idle(4);
      for (int k = 0; k < 12; k++) send_bit(k[1]);
      rst_n = 1'b0; se = 1'b0; idle(3); rst_n = 1'b1; idle(5);
      clear_model();
      check_all("R11");
      fb[0] = dev_byte(strap, 1'b0); fb[1] = 8'd20; fb[2] = 8'hD2; fb[3] = 8'h2D; fb[4] = 8'h77;
      frame(5, 0);
      check_all("R11");

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule